// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a larger chip. An external controller reaches a bank of 16-bit control registers over a serial link made of an active-low select, a serial clock and a data line. Each transfer is a 24-bit frame. The first eight bits are the command: the leading bit chooses read or write, and the next seven bits give the register index. Sixteen data bits follow. Both parts are sent most significant bit first. A write frame updates the chosen register. A read frame returns its contents on the way back.

The link works in one of two wiring modes. In three-wire mode the single data line carries commands inward and read data outward, and the spare output pin is left floating. Three-wire mode is the state after reset. In four-wire mode the data line only receives, and read data leaves on the dedicated output pin. The mode is chosen by bit 15 of register 0, so one write made in three-wire mode is enough to switch over. All link inputs are sampled by the core clock through synchronizers, and edges of the serial clock are found from the sampled values. The whole register bank is also presented in parallel to the rest of the chip.

Top module: `spi_cfg_slave`

## Requirements
- R1: An active-low asynchronous reset sets every register to its default. Register 0 resets to 0x0000. Register i (i > 0) resets to {i[7:0], ~i[7:0]}, so register 5 is 0x05FA and register 3 is 0x03FC.
- R2: In a frame whose first bit is 0 (write), bits 2 to 8 give the register index (MSB first) and bits 9 to 24 give the data (MSB first). The register takes the data once the 24th serial-clock rising edge has been received, and the same value appears on `cfg_regs[16*i +: 16]`.
- R3: In a frame whose first bit is 1 (read), the block returns D15 down to D0 of the indexed register. Each bit is valid at one of the serial-clock rising edges 9 to 24. The data output changes only after falling edges.
- R4: A read frame leaves the register contents unchanged.
- R5: If the select returns high before 24 rising edges have arrived, the frame is abandoned and no register changes.
- R6: In three-wire mode (register 0 bit 15 = 0), the data line is driven only during the 16 data-bit times of a read, and the dedicated output pin stays at high impedance.
- R7: When register 0 bit 15 is 1 (four-wire mode), read data is driven on the dedicated output pin and the data line is never driven. Writing bit 15 back to 0 restores three-wire mode for the following frames.
- R8: Register indices at or above NUM_REGS read as 0x0000, and writes to those indices change nothing.
- R9: Serial-clock edges after the 24th edge, while the select stays low, are ignored. A new frame begins only after the select has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the link |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_csn | input | 1 | Frame select, active low |
| spi_sclk | input | 1 | Serial clock from the controller |
| spi_sdio | inout | 1 | Serial data: bidirectional in three-wire mode, input only in four-wire mode |
| spi_sdo | output | 1 | Dedicated read-data pin, high impedance except during four-wire reads |
| cfg_regs | output | NUM_REGS*16 | All registers in parallel, register i at bits 16*i+15 down to 16*i |

## Verification
The assertions take for granted that the serial clock is slow against the core clock. Each serial-clock level and each data bit must last for several core cycles, so that a rising and a falling edge are never seen in the same cycle and data is stable when an edge is detected. They also take for granted that the select is held high for longer than the synchronizer depth between frames. The stimulus keeps every serial-clock half period at six core cycles. It changes data only while the serial clock is low, places six-cycle gaps around the select edges, and releases the data line at the start of the read data phase.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int CMD_BITS   = 8;
  localparam int DATA_W     = 16;
  localparam int FRAME_BITS = CMD_BITS + DATA_W;
  localparam int ADDR_W     = CMD_BITS - 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int MODE_REG   = 0;
  localparam int MODE_BIT   = 15;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_CMD,
    PH_DATA,
    PH_DONE
  } phase_e;

  // Default contents: register 0 is clear, others carry their index and its inverse
  function automatic logic [DATA_W-1:0] reg_default(input int unsigned idx);
    logic [7:0] b;
    b = 8'(idx);
    if (idx == 0) return '0;
    return {b, ~b};
  endfunction

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_in[g]};
    end
    assign sync_out[g] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              dout,
  output logic              rd_oe
);

  localparam logic [CNT_W-1:0] CNT_CMD_END  = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME_BITS);

  logic              sclk_prev_q, csn_prev_q;
  logic              sclk_rise, sclk_fall, csn_rise;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [DATA_W-2:0] data_q;
  logic [DATA_W-1:0] out_q;
  logic              is_read;
  phase_e            phase;

  // Edge events seen through the synchronized link signals
  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign csn_rise  = csn_s & ~csn_prev_q;
  assign is_read   = cmd_q[CMD_BITS-1];

  always_comb begin
    if (csn_s)                        phase = PH_IDLE;
    else if (bit_cnt_q < CNT_CMD_END) phase = PH_CMD;
    else if (bit_cnt_q < CNT_FULL)    phase = PH_DATA;
    else                              phase = PH_DONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_prev_q <= 1'b0;
      csn_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      csn_prev_q  <= csn_s;
    end
  end

  // Inbound shifting and commit on the final rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      cmd_q     <= '0;
      data_q    <= '0;
      wr_stb    <= 1'b0;
      wr_data   <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (phase == PH_IDLE) begin
        bit_cnt_q <= '0;
      end else if (sclk_rise && phase != PH_DONE) begin
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (phase == PH_CMD) begin
          cmd_q <= {cmd_q[CMD_BITS-2:0], sdi_s};
        end else if (bit_cnt_q != CNT_LAST) begin
          data_q <= {data_q[DATA_W-3:0], sdi_s};
        end else if (!is_read) begin
          wr_data <= {data_q, sdi_s};
          wr_stb  <= 1'b1;
        end
      end
    end
  end

  assign wr_addr = cmd_q[ADDR_W-1:0];
  assign rd_addr = cmd_q[ADDR_W-1:0];

  // Outbound read data, updated on falling edges only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      rd_oe <= 1'b0;
    end else if (phase == PH_IDLE) begin
      rd_oe <= 1'b0;
    end else if (sclk_fall) begin
      if (bit_cnt_q == CNT_CMD_END && is_read) begin
        out_q <= rd_data;
        rd_oe <= 1'b1;
      end else if (phase == PH_DATA) begin
        out_q <= {out_q[DATA_W-2:0], 1'b0};
      end else if (phase == PH_DONE) begin
        rd_oe <= 1'b0;
      end
    end
  end

  assign dout = out_q[DATA_W-1];

  AST_DOUT_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && rd_oe) |-> $stable(dout)); // R3

  AST_OE_READ_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (is_read && (phase == PH_DATA || phase == PH_DONE))); // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    csn_rise |=> (bit_cnt_q == '0 && !rd_oe)); // R5

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt_q <= CNT_FULL); // R9

endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       csn_s,
  input  logic                       wr_stb,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  output logic                       mode4,
  output logic [NUM_REGS*DATA_W-1:0] cfg_flat
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic wr_hit, rd_hit;

  assign wr_hit = wr_stb && ({1'b0, wr_addr} < LIMIT);
  assign rd_hit = {1'b0, rd_addr} < LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reg_default(i);
    end else if (wr_hit) begin
      regs_q[wr_addr[IDX_W-1:0]] <= wr_data;
    end
  end

  assign rd_data  = rd_hit ? regs_q[rd_addr[IDX_W-1:0]] : '0;
  assign mode4    = regs_q[MODE_REG][MODE_BIT];
  assign cfg_flat = regs_q;

  AST_WR_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !csn_s); // R5

  AST_MODE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(mode4)); // R7

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
  import spi_cfg_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_csn,
  input  logic                       spi_sclk,
  inout  wire                        spi_sdio,
  output wire                        spi_sdo,
  output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);

  logic [2:0]        link_s;
  logic              csn_s, sclk_s, sdi_s;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              wr_stb, dout, rd_oe, mode4;
  logic              sdio_oe, sdo_oe;

  spi_cfg_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b001)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({spi_sdio, spi_sclk, spi_csn}),
    .sync_out(link_s)
  );

  assign csn_s  = link_s[0];
  assign sclk_s = link_s[1];
  assign sdi_s  = link_s[2];

  spi_cfg_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .csn_s(csn_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .dout(dout), .rd_oe(rd_oe)
  );

  spi_cfg_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .csn_s(csn_s),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .mode4(mode4), .cfg_flat(cfg_regs)
  );

  // Pin steering by wiring mode
  assign sdio_oe  = rd_oe & ~mode4;
  assign sdo_oe   = rd_oe & mode4;
  assign spi_sdio = sdio_oe ? dout : 1'bz;
  assign spi_sdo  = sdo_oe  ? dout : 1'bz;

  AST_ONE_PIN_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdio_oe && sdo_oe)); // R7

endmodule

// File: tb/spi_cfg_slave_bench.sv
module spi_cfg_slave_bench;

  localparam int NREGS = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csn = 1'b1, sclk = 1'b0, m_oe = 1'b0, m_bit = 1'b0;
  wire  spi_sdio, spi_sdo;
  logic [NREGS*16-1:0] cfg_regs;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { string req; logic [15:0] val; } exp_t;
  exp_t        exp_q[$];
  logic [15:0] act_q[$];

  always #10 clk = ~clk;

  assign spi_sdio = m_oe ? m_bit : 1'bz;
  pullup (spi_sdio);
  pullup (spi_sdo);

  spi_cfg_slave #(.NUM_REGS(NREGS), .SYNC_STAGES(2)) u_spi_cfg_slave (
    .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk),
    .spi_sdio(spi_sdio), .spi_sdo(spi_sdo), .cfg_regs(cfg_regs)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Frame driver: master drives bits while SCLK low, samples before each rise
  task automatic xfer(input logic rd, input logic [6:0] addr, input logic [15:0] wd,
                      input int nbits, input logic four,
                      output logic [15:0] got, output logic other_high);
    logic [23:0] fr;
    fr = {rd, addr, wd};
    got = '0;
    other_high = 1'b1;
    csn = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 8 || !rd) begin
        m_oe = 1'b1;
        m_bit = (i < 24) ? fr[23-i] : 1'b1;
      end else begin
        m_oe = 1'b0;
      end
      repeat (6) @(negedge clk);
      if (rd && i >= 8 && i < 24) begin
        got = {got[14:0], four ? spi_sdo : spi_sdio};
        if ((four ? spi_sdio : spi_sdo) !== 1'b1) other_high = 1'b0;
      end
      sclk = 1'b1;
      repeat (6) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    m_oe = 1'b0;
    csn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic wr(input logic [6:0] addr, input logic [15:0] d, input int nbits);
    logic [15:0] g;
    logic oh;
    xfer(1'b0, addr, d, nbits, 1'b0, g, oh);
  endtask

  // Read and hand the result to the scoreboard
  task automatic rd_sb(input string req, input logic [6:0] addr, input logic [15:0] exp,
                       input logic four, output logic other_high);
    logic [15:0] g;
    exp_q.push_back('{req, exp});
    xfer(1'b1, addr, 16'h0000, 24, four, g, other_high);
    act_q.push_back(g);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        exp_t e;
        logic [15:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        chk(e.req, a, e.val);
      end
    end
  end

  initial begin
    logic oh;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state at the ports
    chk("R1 cfg reg5 default", cfg_regs[5*16 +: 16], 16'h05FA);
    chk("R1 cfg reg0 default", cfg_regs[0 +: 16], 16'h0000);
    chk("R6 sdo idle high-z", {15'd0, spi_sdo}, 16'h0001);
    rd_sb("R1 read reg5 default", 7'd5, 16'h05FA, 1'b0, oh);
    rd_sb("R6 read reg0 on sdio", 7'd0, 16'h0000, 1'b0, oh);
    chk("R6 sdo undriven in 3-wire read", {15'd0, oh}, 16'h0001);
    rd_sb("R1 read last reg default", 7'(NREGS-1), 16'h1FE0, 1'b0, oh);

    // R2 writes, R3 reads
    wr(7'd3, 16'h1234, 24);
    chk("R2 cfg reg3 after write", cfg_regs[3*16 +: 16], 16'h1234);
    rd_sb("R3 read reg3", 7'd3, 16'h1234, 1'b0, oh);
    wr(7'd7, 16'hA5C3, 24);
    rd_sb("R3 read reg7", 7'd7, 16'hA5C3, 1'b0, oh);
    wr(7'd1, 16'hFFFF, 24);
    rd_sb("R2 read reg1 all ones", 7'd1, 16'hFFFF, 1'b0, oh);

    // R4 read is non-destructive
    rd_sb("R4 reread reg7", 7'd7, 16'hA5C3, 1'b0, oh);
    chk("R4 cfg reg7 unchanged", cfg_regs[7*16 +: 16], 16'hA5C3);

    // R5 aborted frames
    wr(7'd3, 16'hDEAD, 12);
    chk("R5 abort after 12 bits", cfg_regs[3*16 +: 16], 16'h1234);
    wr(7'd3, 16'hBEEF, 23);
    chk("R5 abort after 23 bits", cfg_regs[3*16 +: 16], 16'h1234);
    rd_sb("R5 reg3 after aborts", 7'd3, 16'h1234, 1'b0, oh);

    // R9 extra clocks beyond the frame
    wr(7'd9, 16'h0F0F, 30);
    chk("R9 extra edges ignored", cfg_regs[9*16 +: 16], 16'h0F0F);
    rd_sb("R9 reg9 readback", 7'd9, 16'h0F0F, 1'b0, oh);

    // R8 unimplemented index
    wr(7'd100, 16'h5555, 24);
    rd_sb("R8 out-of-range reads zero", 7'd100, 16'h0000, 1'b0, oh);
    chk("R8 reg4 untouched", cfg_regs[4*16 +: 16], 16'h04FB);

    // R7 four-wire mode
    wr(7'd0, 16'h8000, 24);
    rd_sb("R7 4-wire read reg3 on sdo", 7'd3, 16'h1234, 1'b1, oh);
    chk("R7 sdio undriven in 4-wire", {15'd0, oh}, 16'h0001);
    rd_sb("R7 4-wire read reg7 on sdo", 7'd7, 16'hA5C3, 1'b1, oh);
    wr(7'd0, 16'h0000, 24);
    rd_sb("R7 back to 3-wire", 7'd3, 16'h1234, 1'b0, oh);
    chk("R7 sdo undriven after return", {15'd0, oh}, 16'h0001);

    // R1 asynchronous reset restores defaults
    #3 rst_n = 1'b0;
    #5 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cfg reg3 after reset", cfg_regs[3*16 +: 16], 16'h03FC);
    rd_sb("R1 read reg7 after reset", 7'd7, 16'h07F8, 1'b0, oh);

    repeat (20) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule